// File: doc/BRIEF.md
# Endpoint Interrupt Request Latch

This block holds one interrupt request flag for each of the eight upper endpoints (8 to 15) of a full-speed USB device controller. Each endpoint has a fixed transfer type: bulk IN, bulk OUT, isochronous IN, isochronous OUT, or a generic slot. The type decides which of the endpoint's level event inputs can raise its flag. The event inputs are IN transfer done, transmit underrun, OUT data ready, receive overflow, isochronous error and a generic auxiliary event. A per-endpoint enable mask, where a 1 means blocked, gates every flag. Once a flag is set it stays set until software writes a 1 to its bit position. One registered interrupt line goes high while any flag is set.

The host CPU reaches the block through a plain single-cycle register port. The port has one select bit: 0 is the request flags, written one-to-clear, and 1 is the mask, written directly. Reads are combinational from a separate select and change no state. The port carries no stream data, so it has no valid/ready handshake and no back-pressure: a write is taken in the cycle its enable is high.

Top module: `usbd_ep_irq_req`

## Requirements
- R1: After reset all request flags read 0, all mask bits read 1, and the interrupt output is 0.
- R2: A request flag becomes 1 only at a clock edge where its mask bit is 0 and at least one of its qualifying events is 1. An event on a masked endpoint leaves that flag at 0, and other endpoints are not affected.
- R3: A set flag stays 1 after its events go back to 0, until software clears it.
- R4: A write with select 0 clears every flag whose data bit is 1. A data bit of 0 leaves its flag unchanged.
- R5: If a flag's set condition and a clearing write to that flag occur in the same cycle, the flag ends the cycle at 1.
- R6: The bulk IN endpoints 10 and 11 (flag bits 2 and 3) qualify only on IN transfer done. The bulk OUT endpoint 12 (bit 4) qualifies only on OUT data ready. All other event inputs of these endpoints have no effect.
- R7: The isochronous IN endpoints 8 and 13 (bits 0 and 5) qualify on IN transfer done or transmit underrun.
- R8: The isochronous OUT endpoints 9 and 14 (bits 1 and 6) qualify on OUT data ready, receive overflow or isochronous error.
- R9: Endpoint 15 (bit 7) qualifies only on its auxiliary event input. Its other event inputs have no effect.
- R10: The interrupt output is the OR of all flags, registered. It changes one clock after the flags change.
- R11: A read with select 0 returns the flags, with bit i belonging to endpoint 8+i. A read with select 1 returns the mask. Reads change no state.
- R12: A write with select 1 loads the mask from the write data. The new mask gates events from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_in_done | input | 8 | IN transfer done, one bit per endpoint |
| ev_tx_urun | input | 8 | Transmit underrun, one bit per endpoint |
| ev_out_rdy | input | 8 | OUT data ready, one bit per endpoint |
| ev_rx_ovf | input | 8 | Receive overflow, one bit per endpoint |
| ev_iso_err | input | 8 | Isochronous error, one bit per endpoint |
| ev_aux | input | 8 | Generic auxiliary event, one bit per endpoint |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 flags (one-to-clear), 1 mask |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read source: 0 flags, 1 mask |
| rd_data | output | 8 | Read data |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
Every event source is driven into every endpoint type. Sources that do not belong to a type are driven on their own, so a wrong source routing shows up as a flag that sets or fails to set. Events arrive first with all endpoints masked and later with a single endpoint masked. This separates global gating from per-bit gating. Clearing writes use all-zero data and also partial data, and one clearing write collides with a held event, which separates the one-to-clear behaviour and set priority from a plain overwrite. A behavioural model runs beside the design and checks the read data and the interrupt line every cycle, which also catches the one-cycle lag of the interrupt.

// File: rtl/epint_pkg.sv
package epint_pkg;

  typedef enum logic [2:0] {
    EPK_BULK_IN  = 3'd0,
    EPK_BULK_OUT = 3'd1,
    EPK_ISO_IN   = 3'd2,
    EPK_ISO_OUT  = 3'd3,
    EPK_GENERIC  = 3'd4
  } ep_kind_e;

  localparam int unsigned KIND_W = 3;

  localparam logic SEL_REQ  = 1'b0;
  localparam logic SEL_MASK = 1'b1;

endpackage

// File: rtl/epint_source_sel.sv
module epint_source_sel
  import epint_pkg::*;
#(
  parameter ep_kind_e KIND = EPK_BULK_IN
) (
  input  logic in_done,
  input  logic tx_urun,
  input  logic out_rdy,
  input  logic rx_ovf,
  input  logic iso_err,
  input  logic aux,
  output logic hit
);

  // Source enables fixed by the endpoint type
  localparam logic USE_IN   = (KIND == EPK_BULK_IN) || (KIND == EPK_ISO_IN);
  localparam logic USE_URUN = (KIND == EPK_ISO_IN);
  localparam logic USE_OUT  = (KIND == EPK_BULK_OUT) || (KIND == EPK_ISO_OUT);
  localparam logic USE_OVF  = (KIND == EPK_ISO_OUT);
  localparam logic USE_ISO  = (KIND == EPK_ISO_OUT);
  localparam logic USE_AUX  = (KIND == EPK_GENERIC);

  always_comb begin
    hit = (USE_IN   & in_done)
        | (USE_URUN & tx_urun)
        | (USE_OUT  & out_rdy)
        | (USE_OVF  & rx_ovf)
        | (USE_ISO  & iso_err)
        | (USE_AUX  & aux);
  end

endmodule

// File: rtl/epint_mask_reg.sv
module epint_mask_reg #(
  parameter int unsigned NUM_EP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NUM_EP-1:0] load_data,
  output logic [NUM_EP-1:0] mask_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (load) begin
      mask_q <= load_data;
    end
  end

  // R12: the mask takes the written value
  a_r12_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (mask_q == $past(load_data)));

  // R12: without a write the mask holds
  a_r12_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(mask_q));

endmodule

// File: rtl/epint_req_array.sv
module epint_req_array #(
  parameter int unsigned NUM_EP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] hit,
  input  logic [NUM_EP-1:0] mask,
  input  logic              clr_en,
  input  logic [NUM_EP-1:0] clr_bits,
  output logic [NUM_EP-1:0] req_q
);

  for (genvar g = 0; g < NUM_EP; g++) begin : g_bit
    logic set_b;
    logic clr_b;

    always_comb begin
      set_b = hit[g] & ~mask[g];
      clr_b = clr_en & clr_bits[g];
    end

    // Set has priority over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_q[g] <= 1'b0;
      end else begin
        req_q[g] <= set_b | (req_q[g] & ~clr_b);
      end
    end

    // R2: no flag rises without an unmasked event
    a_r2_gated_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_q[g] && (mask[g] || !hit[g])) |=> !req_q[g]);

    // R5: an unmasked event always leaves the flag set
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[g] && !mask[g]) |=> req_q[g]);

    // R4: a one-to-clear write without a new event clears the flag
    a_r4_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && clr_bits[g] && !(hit[g] && !mask[g])) |=> !req_q[g]);

    // R3: without a clear a set flag holds
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q[g] && !(clr_en && clr_bits[g])) |=> req_q[g]);
  end

endmodule

// File: rtl/usbd_ep_irq_req.sv
module usbd_ep_irq_req
  import epint_pkg::*;
#(
  parameter int unsigned NUM_EP = 8,
  // Type of each endpoint slot, KIND_W bits per slot, slot 0 lowest
  parameter logic [KIND_W*NUM_EP-1:0] EP_KIND_MAP =
    {3'd4, 3'd3, 3'd2, 3'd1, 3'd0, 3'd0, 3'd3, 3'd2}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] ev_in_done,
  input  logic [NUM_EP-1:0] ev_tx_urun,
  input  logic [NUM_EP-1:0] ev_out_rdy,
  input  logic [NUM_EP-1:0] ev_rx_ovf,
  input  logic [NUM_EP-1:0] ev_iso_err,
  input  logic [NUM_EP-1:0] ev_aux,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [NUM_EP-1:0] wr_data,
  input  logic              rd_sel,
  output logic [NUM_EP-1:0] rd_data,
  output logic              irq_o
);

  logic [NUM_EP-1:0] hit;
  logic [NUM_EP-1:0] mask_q;
  logic [NUM_EP-1:0] req_q;
  logic              mask_load;
  logic              req_clr;

  for (genvar g = 0; g < NUM_EP; g++) begin : g_src
    epint_source_sel #(
      .KIND(ep_kind_e'(EP_KIND_MAP[KIND_W*g +: KIND_W]))
    ) u_sel (
      .in_done(ev_in_done[g]),
      .tx_urun(ev_tx_urun[g]),
      .out_rdy(ev_out_rdy[g]),
      .rx_ovf (ev_rx_ovf[g]),
      .iso_err(ev_iso_err[g]),
      .aux    (ev_aux[g]),
      .hit    (hit[g])
    );
  end

  always_comb begin
    mask_load = wr_en & (wr_sel == SEL_MASK);
    req_clr   = wr_en & (wr_sel == SEL_REQ);
  end

  epint_mask_reg #(.NUM_EP(NUM_EP)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (mask_load),
    .load_data(wr_data),
    .mask_q   (mask_q)
  );

  epint_req_array #(.NUM_EP(NUM_EP)) u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (hit),
    .mask    (mask_q),
    .clr_en  (req_clr),
    .clr_bits(wr_data),
    .req_q   (req_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
    end else begin
      irq_o <= |req_q;
    end
  end

  always_comb begin
    rd_data = (rd_sel == SEL_MASK) ? mask_q : req_q;
  end

  // R10: the line follows the flags with one cycle of lag
  a_r10_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q != '0) |=> irq_o);

  a_r10_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q == '0) |=> !irq_o);

endmodule

// File: tb/usbd_ep_irq_req_test.sv
`timescale 1ns/10ps
module usbd_ep_irq_req_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ev_in_done = '0, ev_tx_urun = '0, ev_out_rdy = '0;
  logic [7:0] ev_rx_ovf = '0, ev_iso_err = '0, ev_aux = '0;
  logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [7:0] m_req, m_mask;
  logic       m_irq;

  always #2.5 clk = ~clk;

  usbd_ep_irq_req uut (
    .clk(clk), .rst_n(rst_n),
    .ev_in_done(ev_in_done), .ev_tx_urun(ev_tx_urun), .ev_out_rdy(ev_out_rdy),
    .ev_rx_ovf(ev_rx_ovf), .ev_iso_err(ev_iso_err), .ev_aux(ev_aux),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq_o(irq_o)
  );

  // Behavioural reference model
  function automatic logic qual(int i);
    case (i)
      0, 5:    return ev_in_done[i] | ev_tx_urun[i];
      1, 6:    return ev_out_rdy[i] | ev_rx_ovf[i] | ev_iso_err[i];
      2, 3:    return ev_in_done[i];
      4:       return ev_out_rdy[i];
      default: return ev_aux[i];
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_req = 8'h00; m_mask = 8'hFF; m_irq = 1'b0;
    end else begin
      logic [7:0] nxt;
      m_irq = (m_req != 0);
      for (int i = 0; i < 8; i++) begin
        logic s, c;
        s = qual(i) && !m_mask[i];
        c = wr_en && !wr_sel && wr_data[i];
        nxt[i] = s || (m_req[i] && !c);
      end
      if (wr_en && wr_sel) m_mask = wr_data;
      m_req = nxt;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R11 per-cycle read", rd_data, rd_sel ? m_mask : m_req);
      chk("R10 per-cycle irq", {7'd0, irq_o}, {7'd0, m_irq});
    end
  end

  task automatic cyc();
    @(negedge clk);
    #0.5;
  endtask

  task automatic rd(input logic s, output logic [7:0] v);
    rd_sel = s;
    #0.2;
    v = rd_data;
    rd_sel = 1'b0;
    #0.1;
  endtask

  task automatic evs_off();
    ev_in_done = '0; ev_tx_urun = '0; ev_out_rdy = '0;
    ev_rx_ovf = '0; ev_iso_err = '0; ev_aux = '0;
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    cyc();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected below 5000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    rd(1'b0, v); chk("R1 flags", v, 8'h00);
    rd(1'b1, v); chk("R1 mask", v, 8'hFF);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
    // R2 all masked
    ev_in_done = '1; ev_out_rdy = '1; ev_aux = '1; ev_tx_urun = '1;
    cyc(); evs_off(); cyc();
    rd(1'b0, v); chk("R2 masked events", v, 8'h00);
    // R12 mask write
    wr(1'b1, 8'h00);
    rd(1'b1, v); chk("R12 mask readback", v, 8'h00);
    // R6 bulk IN ep10
    ev_in_done = 8'h04;
    cyc(); evs_off();
    rd(1'b0, v); chk("R6 ep10 IN done", v, 8'h04);
    chk("R10 irq lag", {7'd0, irq_o}, 8'h00);
    cyc();
    chk("R10 irq rise", {7'd0, irq_o}, 8'h01);
    cyc(); cyc();
    rd(1'b0, v); chk("R3 sticky", v, 8'h04);
    // R4 one-to-clear
    wr(1'b0, 8'h00);
    rd(1'b0, v); chk("R4 zero write", v, 8'h04);
    wr(1'b0, 8'h04);
    rd(1'b0, v); chk("R4 clear", v, 8'h00);
    cyc();
    chk("R10 irq fall", {7'd0, irq_o}, 8'h00);
    // R6 wrong sources ignored on bulk endpoints
    ev_tx_urun = 8'h1C; ev_rx_ovf = 8'h1C; ev_iso_err = 8'h1C; ev_aux = 8'h1C;
    ev_out_rdy = 8'h0C; ev_in_done = 8'h10;
    cyc(); evs_off(); cyc();
    rd(1'b0, v); chk("R6 foreign sources", v, 8'h00);
    // R7 iso IN
    ev_tx_urun = 8'h20; ev_in_done = 8'h01;
    cyc(); evs_off();
    rd(1'b0, v); chk("R7 iso IN", v, 8'h21);
    // R8 iso OUT
    ev_iso_err = 8'h40; ev_rx_ovf = 8'h02;
    cyc(); evs_off();
    rd(1'b0, v); chk("R8 iso err/ovf", v, 8'h63);
    wr(1'b0, 8'hFF);
    ev_out_rdy = 8'h42;
    cyc(); evs_off();
    rd(1'b0, v); chk("R8 out ready", v, 8'h42);
    wr(1'b0, 8'hFF);
    // R9 generic endpoint
    ev_in_done = 8'h80; ev_out_rdy = 8'h80; ev_tx_urun = 8'h80;
    ev_rx_ovf = 8'h80; ev_iso_err = 8'h80;
    cyc(); evs_off(); cyc();
    rd(1'b0, v); chk("R9 ignored", v, 8'h00);
    ev_aux = 8'h80;
    cyc(); evs_off();
    rd(1'b0, v); chk("R9 aux", v, 8'h80);
    // R5 set beats clear
    ev_out_rdy = 8'h10;
    wr(1'b0, 8'h90);
    evs_off();
    rd(1'b0, v); chk("R5 set wins", v, 8'h10);
    // R2 single masked endpoint
    wr(1'b1, 8'h10);
    wr(1'b0, 8'hFF);
    ev_out_rdy = 8'h52;
    cyc(); evs_off();
    rd(1'b0, v); chk("R2 per-bit mask", v, 8'h42);
    // R11 reads have no side effects
    rd(1'b0, v); chk("R11 reread", v, 8'h42);
    rd(1'b1, v); chk("R11 mask read", v, 8'h10);
    cyc();
    rd(1'b0, v); chk("R11 stable", v, 8'h42);
    cyc();
    finish_run();
  end

endmodule